// File: doc/BRIEF.md
# HyperBus Manual Transaction Engine

This block runs one HyperBus transaction at a time for a register-style front end. A single start pulse captures a request made of a read/write flag, a space select (memory or register), a burst-type bit, a byte address, a size code and up to 64 bits of write data. The engine builds the 48-bit command-address word, drives it onto an 8-bit bus, and then either sends the write payload or waits out the read latency and collects the returned bytes.

The bus runs at double data rate. One byte moves in each cycle of `clk_i`, and `hb_ck_o` toggles every cycle while the device is selected, so each edge of the bus clock carries one byte. In register space every 16-bit word is byte-swapped on the bus. In memory space words pass through unchanged. When the transfer finishes, a transfer-end flag rises, and read results stay in two 32-bit read-data outputs until the next read completes.

Top module: `hb_xfer_engine`

## Requirements
- R1: Command-address bit 47 is 1 for a read and 0 for a write. Bit 46 is 1 for register space and 0 for memory space. Bit 45 is 1 for linear burst and 0 for wrapped burst.
- R2: Bits 23:0 of the command-address word hold the byte address shifted right by one, and bits 44:24 are zero. The word goes out most significant byte first, one byte per cycle. `hb_ck_o` toggles each cycle while `hb_cs_no` is low and is low whenever `hb_cs_no` is high.
- R3: Size code 0xF moves 8 payload bytes, 0xC moves 4, and 0x8 moves 2. Any other code is treated as 0x8.
- R4: A read leaves the bus undriven for 2×14 cycles (14 bus-clock periods) between the last command-address byte and the first data byte. A write sends its data in the cycle right after the last command-address byte.
- R5: The words of a write are taken in this order. For 16 bits: `wdata_lo_i[31:16]`. For 32 bits: `wdata_lo_i[15:0]`, then `wdata_lo_i[31:16]`. For 64 bits: `wdata_hi_i[15:0]`, `wdata_hi_i[31:16]`, `wdata_lo_i[15:0]`, `wdata_lo_i[31:16]`.
- R6: In memory space each 16-bit word travels low byte first. In register space it travels high byte first. This holds for both writes and reads.
- R7: Read words w0..w3 land as follows. For 16 bits: `rdata_lo_o={w0,16'h0}`. For 32 bits: `rdata_lo_o={w1,w0}`. For 64 bits: `rdata_hi_o={w1,w0}` and `rdata_lo_o={w3,w2}`. The unused read-data bits are zero.
- R8: `xfer_end_o` falls in the cycle after an accepted start. It rises, with `hb_cs_no` high, one cycle after the last data byte.
- R9: A start pulse that arrives while a transfer is in progress is ignored.
- R10: A write transfer leaves `rdata_lo_o` and `rdata_hi_o` unchanged.
- R11: After reset, `xfer_end_o` is 1, `hb_cs_no` is 1, `hb_ck_o` and `hb_dq_oe_o` are 0, and both read-data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, one bus byte per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| read_i | input | 1 | 1 = read, 0 = write |
| reg_space_i | input | 1 | 1 = register space, 0 = memory space |
| linear_i | input | 1 | 1 = linear burst, 0 = wrapped burst |
| byte_addr_i | input | ADDR_W | Byte address of the transfer |
| size_code_i | input | 4 | Size code 0x8 / 0xC / 0xF |
| wdata_lo_i | input | 32 | Low write-data word |
| wdata_hi_i | input | 32 | High write-data word (64-bit transfers) |
| rdata_lo_o | output | 32 | Low read-data word |
| rdata_hi_o | output | 32 | High read-data word |
| xfer_end_o | output | 1 | Transfer-end flag |
| hb_cs_no | output | 1 | Bus chip select, active low |
| hb_ck_o | output | 1 | Bus clock |
| hb_dq_o | output | 8 | Bus data out |
| hb_dq_oe_o | output | 1 | Bus data output enable |
| hb_dq_i | input | 8 | Bus data in |

## Verification
The assertions check the following on every cycle:
- the first command-address byte carries the read flag captured at start;
- the bus clock and output enable stay quiet while the device is deselected;
- the end flag drops on an accepted start and only rises with chip select high;
- the captured request does not change during a transfer;
- the read-data outputs hold steady through writes.

Other behaviour depends on full transactions, so only the bench scenarios can show it:
- the halved address;
- the exact latency gap;
- the payload length for each size code;
- word sourcing and per-space byte order.

For these, a behavioural bus slave in the bench logs every driven byte and returns a known pattern on reads.

// File: rtl/hb_xfer_pkg.sv
package hb_xfer_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CA   = 3'd1,
    S_LAT  = 3'd2,
    S_DATA = 3'd3,
    S_END  = 3'd4
  } seq_state_e;

  localparam logic [3:0] SZ_W16 = 4'h8;
  localparam logic [3:0] SZ_W32 = 4'hC;
  localparam logic [3:0] SZ_W64 = 4'hF;

  localparam int CA_BYTES = 6;
  localparam int CA_W     = 8 * CA_BYTES;
  localparam int MAX_WORDS = 4;

  function automatic logic [3:0] size_bytes(input logic [3:0] code);
    case (code)
      SZ_W64:  return 4'd8;
      SZ_W32:  return 4'd4;
      default: return 4'd2;
    endcase
  endfunction

  // Stream word {second byte, first byte}; register space swaps.
  function automatic logic [15:0] bus_word(input logic [15:0] w, input logic swap);
    return swap ? {w[7:0], w[15:8]} : w;
  endfunction

endpackage

// File: rtl/hb_ca_builder.sv
module hb_ca_builder
  import hb_xfer_pkg::*;
#(
  parameter int ADDR_W = 25
) (
  input  logic              rd_i,
  input  logic              rsp_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  output logic [CA_W-1:0]   ca_o
);
  localparam int WADDR_W = ADDR_W - 1;
  localparam int PAD_W   = CA_W - 3 - WADDR_W;

  logic [WADDR_W-1:0] word_addr;
  logic               addr_lsb_unused;

  assign word_addr       = byte_addr_i[ADDR_W-1:1];
  assign addr_lsb_unused = byte_addr_i[0];
  assign ca_o            = {rd_i, rsp_i, lin_i, {PAD_W{1'b0}}, word_addr};

endmodule

// File: rtl/hb_wdata_pack.sv
module hb_wdata_pack
  import hb_xfer_pkg::*;
(
  input  logic [31:0] wdata_lo_i,
  input  logic [31:0] wdata_hi_i,
  input  logic [3:0]  size_code_i,
  input  logic        rsp_i,
  output logic [63:0] stream_o
);
  logic [15:0] words [MAX_WORDS];

  always_comb begin
    for (int k = 0; k < MAX_WORDS; k++) words[k] = 16'h0000;
    case (size_code_i)
      SZ_W64: begin
        words[0] = wdata_hi_i[15:0];
        words[1] = wdata_hi_i[31:16];
        words[2] = wdata_lo_i[15:0];
        words[3] = wdata_lo_i[31:16];
      end
      SZ_W32: begin
        words[0] = wdata_lo_i[15:0];
        words[1] = wdata_lo_i[31:16];
      end
      default: words[0] = wdata_lo_i[31:16];
    endcase
  end

  for (genvar k = 0; k < MAX_WORDS; k++) begin : g_word
    assign stream_o[16*k +: 16] = bus_word(words[k], rsp_i);
  end

endmodule

// File: rtl/hb_rdata_unpack.sv
module hb_rdata_unpack
  import hb_xfer_pkg::*;
(
  input  logic [63:0] stream_i,
  input  logic [3:0]  size_code_i,
  input  logic        rsp_i,
  output logic [31:0] rdata_lo_o,
  output logic [31:0] rdata_hi_o
);
  logic [15:0] w [MAX_WORDS];

  for (genvar k = 0; k < MAX_WORDS; k++) begin : g_word
    assign w[k] = bus_word(stream_i[16*k +: 16], rsp_i);
  end

  always_comb begin
    rdata_lo_o = '0;
    rdata_hi_o = '0;
    case (size_code_i)
      SZ_W64: begin
        rdata_hi_o = {w[1], w[0]};
        rdata_lo_o = {w[3], w[2]};
      end
      SZ_W32:  rdata_lo_o = {w[1], w[0]};
      default: rdata_lo_o = {w[0], 16'h0000};
    endcase
  end

endmodule

// File: rtl/hb_seq.sv
module hb_seq
  import hb_xfer_pkg::*;
#(
  parameter int DUMMY_CYC = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rd_i,
  input  logic [3:0] n_bytes_i,
  output logic       accept_o,
  output seq_state_e state_o
);
  localparam int LAT_TICKS = 2 * DUMMY_CYC;
  localparam int CNT_RAW   = $clog2(LAT_TICKS + 1);
  localparam int CNT_W     = (CNT_RAW < 3) ? 3 : CNT_RAW;
  localparam logic [CNT_W-1:0] CA_LAST  = CNT_W'(CA_BYTES - 1);
  localparam logic [CNT_W-1:0] LAT_LAST = CNT_W'(LAT_TICKS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] data_last;

  assign data_last = CNT_W'(n_bytes_i - 4'd1);
  assign accept_o  = (state_q == S_IDLE) && start_i;
  assign state_o   = state_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    case (state_q)
      S_IDLE: begin
        cnt_d = '0;
        if (start_i) state_d = S_CA;
      end
      S_CA: if (cnt_q == CA_LAST) begin
        cnt_d   = '0;
        state_d = rd_i ? S_LAT : S_DATA;
      end
      S_LAT: if (cnt_q == LAT_LAST) begin
        cnt_d   = '0;
        state_d = S_DATA;
      end
      S_DATA: if (cnt_q == data_last) begin
        cnt_d   = '0;
        state_d = S_END;
      end
      S_END: begin
        cnt_d   = '0;
        state_d = S_IDLE;
      end
      default: begin
        cnt_d   = '0;
        state_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/hb_xfer_engine.sv
module hb_xfer_engine
  import hb_xfer_pkg::*;
#(
  parameter int ADDR_W    = 25,
  parameter int DUMMY_CYC = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              read_i,
  input  logic              reg_space_i,
  input  logic              linear_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [3:0]        size_code_i,
  input  logic [31:0]       wdata_lo_i,
  input  logic [31:0]       wdata_hi_i,
  output logic [31:0]       rdata_lo_o,
  output logic [31:0]       rdata_hi_o,
  output logic              xfer_end_o,
  output logic              hb_cs_no,
  output logic              hb_ck_o,
  output logic [7:0]        hb_dq_o,
  output logic              hb_dq_oe_o,
  input  logic [7:0]        hb_dq_i
);
  seq_state_e  state;
  logic        accept;
  logic [CA_W-1:0] ca_w, ca_q;
  logic [63:0] tx_w, tx_q, rx_q, rx_aligned;
  logic [31:0] rd_lo_w, rd_hi_w, rd_lo_q, rd_hi_q;
  logic        rd_q, rsp_q;
  logic [3:0]  size_q, nbytes_q;
  logic        ck_q, end_q, active;

  hb_ca_builder #(.ADDR_W(ADDR_W)) u_ca (
    .rd_i       (read_i),
    .rsp_i      (reg_space_i),
    .lin_i      (linear_i),
    .byte_addr_i(byte_addr_i),
    .ca_o       (ca_w)
  );

  hb_wdata_pack u_pack (
    .wdata_lo_i (wdata_lo_i),
    .wdata_hi_i (wdata_hi_i),
    .size_code_i(size_code_i),
    .rsp_i      (reg_space_i),
    .stream_o   (tx_w)
  );

  hb_seq #(.DUMMY_CYC(DUMMY_CYC)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .rd_i     (rd_q),
    .n_bytes_i(nbytes_q),
    .accept_o (accept),
    .state_o  (state)
  );

  // Received bytes enter from the top; realign so byte 0 sits at bit 0.
  assign rx_aligned = rx_q >> {4'd8 - nbytes_q, 3'b000};

  hb_rdata_unpack u_unpack (
    .stream_i   (rx_aligned),
    .size_code_i(size_q),
    .rsp_i      (rsp_q),
    .rdata_lo_o (rd_lo_w),
    .rdata_hi_o (rd_hi_w)
  );

  assign active = (state == S_CA) || (state == S_LAT) || (state == S_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ca_q     <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      rd_q     <= 1'b0;
      rsp_q    <= 1'b0;
      size_q   <= SZ_W16;
      nbytes_q <= 4'd2;
    end else if (accept) begin
      ca_q     <= ca_w;
      tx_q     <= tx_w;
      rx_q     <= '0;
      rd_q     <= read_i;
      rsp_q    <= reg_space_i;
      size_q   <= size_code_i;
      nbytes_q <= size_bytes(size_code_i);
    end else begin
      if (state == S_CA) ca_q <= {ca_q[CA_W-9:0], 8'h00};
      if (state == S_DATA && !rd_q) tx_q <= {8'h00, tx_q[63:8]};
      if (state == S_DATA && rd_q) rx_q <= {hb_dq_i, rx_q[63:8]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q    <= 1'b0;
      end_q   <= 1'b1;
      rd_lo_q <= '0;
      rd_hi_q <= '0;
    end else begin
      ck_q <= active ? ~ck_q : 1'b0;
      if (accept) end_q <= 1'b0;
      else if (state == S_END) end_q <= 1'b1;
      if (state == S_END && rd_q) begin
        rd_lo_q <= rd_lo_w;
        rd_hi_q <= rd_hi_w;
      end
    end
  end

  assign hb_cs_no   = ~active;
  assign hb_ck_o    = ck_q;
  assign hb_dq_oe_o = (state == S_CA) || (state == S_DATA && !rd_q);
  assign hb_dq_o    = (state == S_CA) ? ca_q[CA_W-1 -: 8] :
                      (hb_dq_oe_o ? tx_q[7:0] : 8'h00);
  assign xfer_end_o = end_q;
  assign rdata_lo_o = rd_lo_q;
  assign rdata_hi_o = rd_hi_q;

endmodule

// File: rtl/hb_xfer_checker.sv
module hb_xfer_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        read_i,
  input logic        xfer_end_o,
  input logic        hb_cs_no,
  input logic        hb_ck_o,
  input logic        hb_dq_oe_o,
  input logic [7:0]  hb_dq_o,
  input logic        rd_q,
  input logic [31:0] rdata_lo_o,
  input logic [31:0] rdata_hi_o
);

  p_ca_read_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && xfer_end_o) |=> (hb_dq_oe_o && hb_dq_o[7] == $past(read_i)));

  p_deselect_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_cs_no |-> (!hb_ck_o && !hb_dq_oe_o));

  p_start_clears_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && xfer_end_o) |=> (!xfer_end_o && !hb_cs_no));

  p_end_deselected_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_o |-> hb_cs_no);

  p_busy_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_end_o |=> $stable(rd_q));

  p_write_keeps_rdata_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_end_o && !rd_q) |=> $stable({rdata_hi_o, rdata_lo_o}));

endmodule

bind hb_xfer_engine hb_xfer_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .read_i     (read_i),
  .xfer_end_o (xfer_end_o),
  .hb_cs_no   (hb_cs_no),
  .hb_ck_o    (hb_ck_o),
  .hb_dq_oe_o (hb_dq_oe_o),
  .hb_dq_o    (hb_dq_o),
  .rd_q       (rd_q),
  .rdata_lo_o (rdata_lo_o),
  .rdata_hi_o (rdata_hi_o)
);

// File: tb/sim_hb_xfer_engine.sv
`timescale 1ns/1ps
module sim_hb_xfer_engine;
  localparam int ADDR_W = 25;
  localparam int LAT    = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0, rsp = 1'b0, lin = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [3:0]  sz = 4'h8;
  logic [31:0] wlo = '0, whi = '0;
  logic [31:0] rlo, rhi;
  logic xend, cs_n, ck, oe;
  logic [7:0] dq_o;
  logic [7:0] dq_in = 8'h00;

  always #2 clk = ~clk;

  hb_xfer_engine #(.ADDR_W(ADDR_W), .DUMMY_CYC(14)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .read_i(rd),
    .reg_space_i(rsp), .linear_i(lin), .byte_addr_i(addr), .size_code_i(sz),
    .wdata_lo_i(wlo), .wdata_hi_i(whi), .rdata_lo_o(rlo), .rdata_hi_o(rhi),
    .xfer_end_o(xend), .hb_cs_no(cs_n), .hb_ck_o(ck), .hb_dq_o(dq_o),
    .hb_dq_oe_o(oe), .hb_dq_i(dq_in)
  );

  int vectors = 0, fails = 0;
  bit done = 0;

  // Behavioural bus slave
  logic [7:0] tx_log [0:15];
  logic [7:0] rd_pat [0:7];
  int n_tx, n_hiz, idx, ck_err;
  logic cur_rd, ck_exp;

  always @(negedge clk) begin
    if (!cs_n) begin
      if (ck !== ck_exp) ck_err++;
      ck_exp = ~ck_exp;
      if (oe) begin
        if (n_tx < 16) tx_log[n_tx] = dq_o;
        n_tx++;
      end else n_hiz++;
      if (cur_rd && idx >= 6 + LAT && idx < 14 + LAT) dq_in = rd_pat[idx - 6 - LAT];
      else dq_in = 8'h00;
      idx++;
    end else begin
      ck_exp = 1'b0;
      if (ck !== 1'b0) ck_err++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int nb_of(input logic [3:0] s);
    return (s == 4'hF) ? 8 : (s == 4'hC) ? 4 : 2;
  endfunction

  function automatic logic [15:0] src_word(input int k, input logic [3:0] s,
                                           input logic [31:0] lo, input logic [31:0] hi);
    if (s == 4'hF) begin
      case (k) 0: return hi[15:0]; 1: return hi[31:16]; 2: return lo[15:0]; default: return lo[31:16]; endcase
    end else if (s == 4'hC) return (k == 0) ? lo[15:0] : lo[31:16];
    return lo[31:16];
  endfunction

  logic [31:0] exp_lo = '0, exp_hi = '0;

  task automatic xfer(input logic r, input logic sp, input logic ln,
                      input logic [ADDR_W-1:0] a, input logic [3:0] s,
                      input logic [31:0] lo, input logic [31:0] hi, input logic extra_start);
    int nb, k, active;
    logic [47:0] ca, ca_exp;
    logic [63:0] pay, pay_exp;
    logic [15:0] w;
    logic [15:0] rw [4];
    @(negedge clk);
    n_tx = 0; n_hiz = 0; idx = 0; ck_err = 0; cur_rd = r; ck_exp = 1'b0;
    rd = r; rsp = sp; lin = ln; addr = a; sz = s; wlo = lo; whi = hi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 end flag low after start", {63'd0, xend}, 64'd0);
    nb = nb_of(s);
    active = 6 + (r ? LAT : 0) + nb;
    k = 0;
    while (!xend && k < 200) begin
      @(negedge clk);
      k++;
      if (extra_start && k == 3) begin
        start = 1'b1; rd = ~r; rsp = ~sp; addr = ~a; sz = 4'hF; wlo = ~lo;
      end else start = 1'b0;
    end
    start = 1'b0;
    chk("R8 cycles to end flag", k, active + 1);
    chk("R8 deselected at end", {63'd0, cs_n}, 64'd1);
    ca = {tx_log[0], tx_log[1], tx_log[2], tx_log[3], tx_log[4], tx_log[5]};
    ca_exp = {r, sp, ln, 21'd0, a[ADDR_W-1:1]};
    chk("R1 ca flag bits", ca[47:45], ca_exp[47:45]);
    chk("R2 ca address field", ca[44:0], ca_exp[44:0]);
    chk("R2 bus clock toggling", ck_err, 0);
    chk("R3 driven byte count", n_tx, 6 + (r ? 0 : nb));
    chk("R4 undriven cycle count", n_hiz, r ? LAT + nb : 0);
    if (!r) begin
      pay = '0; pay_exp = '0;
      for (int i = 0; i < nb; i++) pay[8*i +: 8] = tx_log[6 + i];
      for (int j = 0; j < nb / 2; j++) begin
        w = src_word(j, s, lo, hi);
        pay_exp[16*j +: 16] = sp ? {w[7:0], w[15:8]} : w;
      end
      chk("R5 R6 write payload", pay, pay_exp);
      chk("R10 rdata unchanged by write", {rhi, rlo}, {exp_hi, exp_lo});
    end else begin
      for (int j = 0; j < 4; j++)
        rw[j] = sp ? {rd_pat[2*j], rd_pat[2*j+1]} : {rd_pat[2*j+1], rd_pat[2*j]};
      if (nb == 8) begin exp_hi = {rw[1], rw[0]}; exp_lo = {rw[3], rw[2]}; end
      else if (nb == 4) begin exp_hi = '0; exp_lo = {rw[1], rw[0]}; end
      else begin exp_hi = '0; exp_lo = {rw[0], 16'h0000}; end
      chk("R7 R6 read data", {rhi, rlo}, {exp_hi, exp_lo});
    end
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] szs [3];
    logic [ADDR_W-1:0] adrs [3];
    int it, seen;
    szs[0] = 4'h8; szs[1] = 4'hC; szs[2] = 4'hF;
    adrs[0] = 25'h0000002; adrs[1] = 25'h1ABCDE6; adrs[2] = 25'h1FFFFFF;
    cur_rd = 1'b0; ck_exp = 1'b0; n_tx = 0; n_hiz = 0; idx = 0; ck_err = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset outputs", {60'd0, xend, cs_n, ck, oe}, {60'd0, 4'b1100});
    chk("R11 reset rdata", {rhi, rlo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    it = 0;
    for (int r = 0; r < 2; r++)
      for (int sp = 0; sp < 2; sp++)
        for (int ln = 0; ln < 2; ln++)
          for (int s = 0; s < 3; s++)
            for (int a = 0; a < 3; a++) begin
              for (int b = 0; b < 8; b++) rd_pat[b] = 8'(8'h11 * b + 8'(it * 7) + 8'h05);
              xfer(r[0], sp[0], ln[0], adrs[a], szs[s],
                   32'hA1B2C3D4 ^ 32'(it * 32'h01030507),
                   32'h5E6F7081 ^ 32'(it * 32'h10305070), 1'b0);
              it++;
            end
    // R3 undefined size code behaves as 16-bit (write and read)
    xfer(1'b0, 1'b0, 1'b1, 25'h0000100, 4'h3, 32'hBEEF1234, 32'h0, 1'b0);
    for (int b = 0; b < 8; b++) rd_pat[b] = 8'(8'hC0 + b);
    xfer(1'b1, 1'b1, 1'b0, 25'h0000100, 4'h0, 32'h0, 32'h0, 1'b0);
    // R9 start during a transfer is ignored
    for (int b = 0; b < 8; b++) rd_pat[b] = 8'(8'h90 + b);
    xfer(1'b1, 1'b0, 1'b1, 25'h0123456, 4'hC, 32'h0, 32'h0, 1'b1);
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (!cs_n) seen++;
    end
    chk("R9 no second transfer after busy start", seen, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule